// File: doc/BRIEF.md
# Next Program Counter Selection Unit

This block works out the address of the next instruction for the fetch stage of a 32-bit RISC core whose instructions are word aligned. It holds the program counter. From the current PC it forms the sequential address PC+4. From the PC and the instruction word now in fetch it also forms two targets: a PC-relative branch target and a pseudo-direct jump target. It then picks one of these, or a register operand for an indirect jump, as the next PC.

A comparator outside the block decides whether a branch condition holds. A register file outside the block supplies the indirect jump operand. The block also puts out the return address and a write strobe for the link register, so that a call instruction can record where to come back to. The PC register loads the next PC only while the pipeline is not stalled, and a synchronous reset places it at a reset vector set by a parameter.

Top module: `npc_select`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc_q` takes the value `RESET_VEC` (default 32'h0040_0000) at that edge, whatever `adv_en` is.
- R2: `seq_pc` equals `pc_q + 4`, taken modulo 2^32, so it wraps from 32'hFFFF_FFFC to 0.
- R3: `br_tgt` equals `seq_pc` plus the low 16 bits of `instr`, read as a signed word offset and shifted left by two (sign-extended). Offsets may point forward or backward.
- R4: `jmp_tgt` is formed from three parts, from the top down: bits 31..28 of `seq_pc`, then `instr[25:0]`, then two zero bits.
- R5: When the opcode `instr[31:26]` is 2 (jump) or 3 (jump-and-link), `npc` equals `jmp_tgt`, whatever `br_taken` is.
- R6: When the opcode is 4 (branch-if-equal) or 5 (branch-not-equal), `npc` equals `br_tgt` if `br_taken` is high and `seq_pc` if it is low.
- R7: For any opcode other than 2, 3, 4 or 5, `br_taken` has no effect. Such an instruction, unless it is the register jump of R8, gives `npc = seq_pc` and `link_we = 0`.
- R8: A register jump is opcode 0 with `instr[5:0] = 8`. It gives `npc = reg_target`, which takes precedence over every other source. The order of precedence is register jump, then the direct jumps, then a taken branch, then the sequential address.
- R9: For opcode 3, `link_we` is 1 and `link_val` equals `seq_pc`. For every other opcode, `link_we` is 0.
- R10: At a rising edge with `rst` low, `pc_q` loads `npc` if `adv_en` is high and keeps its value if `adv_en` is low.
- R11: With `pc_q` at byte address 80020 (decimal), a jump whose 26-bit field is 20000 gives `npc = 80000`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| adv_en | input | 1 | High when fetch may advance, low during a stall |
| instr | input | 32 | Instruction word currently in fetch |
| br_taken | input | 1 | Branch condition result from the external comparator |
| reg_target | input | 32 | Register operand for a register jump |
| pc_q | output | 32 | Current program counter |
| seq_pc | output | 32 | Sequential address, PC+4 |
| br_tgt | output | 32 | PC-relative branch target |
| jmp_tgt | output | 32 | Pseudo-direct jump target |
| npc | output | 32 | Selected next PC |
| link_val | output | 32 | Return address for jump-and-link |
| link_we | output | 1 | Write strobe for the link register |

## Verification
Every derived output (`seq_pc`, `br_tgt`, `jmp_tgt`, `npc`, `link_val`, `link_we`) is combinational from `pc_q` and the inputs, so it is due in the same cycle that the stimulus is applied. The bench drives inputs on the falling edge and samples these outputs one nanosecond later, before the next rising edge. `pc_q` goes through one register, so it is due one rising edge after the stimulus and is sampled one nanosecond after that edge. The bench sets arbitrary PC values by issuing a register jump and advancing one edge, then sweeps branch offsets and jump indices from there.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int OP_W    = 6;
    localparam int FN_W    = 6;

    localparam logic [OP_W-1:0] OP_SPECIAL = 6'd0;
    localparam logic [OP_W-1:0] OP_JMP     = 6'd2;
    localparam logic [OP_W-1:0] OP_JAL     = 6'd3;
    localparam logic [OP_W-1:0] OP_BEQ     = 6'd4;
    localparam logic [OP_W-1:0] OP_BNE     = 6'd5;
    localparam logic [FN_W-1:0] FN_JREG    = 6'd8;

    typedef enum logic [1:0] {
        SRC_SEQ = 2'd0,
        SRC_BR  = 2'd1,
        SRC_JMP = 2'd2,
        SRC_REG = 2'd3
    } npc_src_e;

    typedef struct packed {
        logic is_jreg;
        logic is_jmp;
        logic is_link;
        logic is_br;
    } op_class_t;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    input  logic [FN_W-1:0] funct,
    output op_class_t       cls
);

    always_comb begin
        cls         = '0;
        cls.is_jreg = (opcode == OP_SPECIAL) && (funct == FN_JREG);
        cls.is_jmp  = (opcode == OP_JMP) || (opcode == OP_JAL);
        cls.is_link = (opcode == OP_JAL);
        cls.is_br   = (opcode == OP_BEQ) || (opcode == OP_BNE);
    end

endmodule

// File: rtl/npc_targets.sv
module npc_targets #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int IDX_W  = 26
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [OFF_W-1:0]  offset,
    input  logic [IDX_W-1:0]  index,
    output logic [ADDR_W-1:0] seq,
    output logic [ADDR_W-1:0] br,
    output logic [ADDR_W-1:0] jmp
);

    localparam int ALIGN  = 2;
    localparam int EXT_W  = ADDR_W - OFF_W - ALIGN;
    localparam int HI_W   = ADDR_W - IDX_W - ALIGN;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1 << ALIGN);

    logic [ADDR_W-1:0] disp;

    always_comb begin
        seq  = pc + STEP;
        disp = {{EXT_W{offset[OFF_W-1]}}, offset, {ALIGN{1'b0}}};
        br   = seq + disp;
        jmp  = {seq[ADDR_W-1 -: HI_W], index, {ALIGN{1'b0}}};
    end

endmodule

// File: rtl/npc_mux.sv
module npc_mux
    import npc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  npc_src_e          src,
    input  logic [ADDR_W-1:0] seq,
    input  logic [ADDR_W-1:0] br,
    input  logic [ADDR_W-1:0] jmp,
    input  logic [ADDR_W-1:0] rgt,
    output logic [ADDR_W-1:0] sel
);

    always_comb begin
        unique case (src)
            SRC_BR:  sel = br;
            SRC_JMP: sel = jmp;
            SRC_REG: sel = rgt;
            default: sel = seq;
        endcase
    end

endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
#(
    parameter int               ADDR_W    = 32,
    parameter int               OFF_W     = 16,
    parameter int               IDX_W     = 26,
    parameter logic [ADDR_W-1:0] RESET_VEC = 32'h0040_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_en,
    input  logic [31:0]       instr,
    input  logic              br_taken,
    input  logic [ADDR_W-1:0] reg_target,
    output logic [ADDR_W-1:0] pc_q,
    output logic [ADDR_W-1:0] seq_pc,
    output logic [ADDR_W-1:0] br_tgt,
    output logic [ADDR_W-1:0] jmp_tgt,
    output logic [ADDR_W-1:0] npc,
    output logic [ADDR_W-1:0] link_val,
    output logic              link_we
);

    localparam int INSTR_W = 32;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
    } state_t;

    state_t    st_d, st_q;
    op_class_t cls;
    npc_src_e  src;

    npc_decode u_dec (
        .opcode (instr[INSTR_W-1 -: OP_W]),
        .funct  (instr[FN_W-1:0]),
        .cls    (cls)
    );

    npc_targets #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .IDX_W  (IDX_W)
    ) u_tgt (
        .pc     (st_q.pc),
        .offset (instr[OFF_W-1:0]),
        .index  (instr[IDX_W-1:0]),
        .seq    (seq_pc),
        .br     (br_tgt),
        .jmp    (jmp_tgt)
    );

    npc_mux #(
        .ADDR_W (ADDR_W)
    ) u_mux (
        .src    (src),
        .seq    (seq_pc),
        .br     (br_tgt),
        .jmp    (jmp_tgt),
        .rgt    (reg_target),
        .sel    (npc)
    );

    always_comb begin
        if (cls.is_jreg)                 src = SRC_REG;
        else if (cls.is_jmp)             src = SRC_JMP;
        else if (cls.is_br && br_taken)  src = SRC_BR;
        else                             src = SRC_SEQ;

        st_d = st_q;
        if (rst)         st_d.pc = RESET_VEC;
        else if (adv_en) st_d.pc = npc;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pc_q     = st_q.pc;
    assign link_we  = cls.is_link;
    assign link_val = seq_pc;

endmodule

// File: rtl/npc_select_chk.sv
module npc_select_chk #(
    parameter int               ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] RESET_VEC = 32'h0040_0000
) (
    input logic              clk,
    input logic              rst,
    input logic              adv_en,
    input logic [31:0]       instr,
    input logic              br_taken,
    input logic [ADDR_W-1:0] reg_target,
    input logic [ADDR_W-1:0] pc_q,
    input logic [ADDR_W-1:0] seq_pc,
    input logic [ADDR_W-1:0] br_tgt,
    input logic [ADDR_W-1:0] jmp_tgt,
    input logic [ADDR_W-1:0] npc,
    input logic [ADDR_W-1:0] link_val,
    input logic              link_we
);

    logic [5:0] op;
    logic       c_jreg, c_jmp, c_br;

    always_comb begin
        op     = instr[31:26];
        c_jreg = (op == 6'd0) && (instr[5:0] == 6'd8);
        c_jmp  = (op == 6'd2) || (op == 6'd3);
        c_br   = (op == 6'd4) || (op == 6'd5);
    end

    p_reset_vec_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> pc_q == RESET_VEC);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !adv_en |=> pc_q == $past(pc_q));

    p_advance_r10: assert property (@(posedge clk) disable iff (rst)
        adv_en |=> pc_q == $past(npc));

    p_jreg_r8: assert property (@(posedge clk) disable iff (rst)
        c_jreg |-> npc == reg_target);

    p_jump_r5: assert property (@(posedge clk) disable iff (rst)
        c_jmp |-> npc == {seq_pc[31:28], instr[25:0], 2'b00});

    p_branch_r6: assert property (@(posedge clk) disable iff (rst)
        (c_br && br_taken) |-> npc == br_tgt);

    p_fallthru_r7: assert property (@(posedge clk) disable iff (rst)
        (!c_jreg && !c_jmp && !(c_br && br_taken)) |-> npc == seq_pc);

    p_link_r9: assert property (@(posedge clk) disable iff (rst)
        link_we |-> (op == 6'd3) && (link_val == seq_pc));

    p_jmp_tgt_r4: assert property (@(posedge clk) disable iff (rst)
        jmp_tgt[1:0] == 2'b00);

endmodule

bind npc_select npc_select_chk #(
    .ADDR_W    (ADDR_W),
    .RESET_VEC (RESET_VEC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .adv_en     (adv_en),
    .instr      (instr),
    .br_taken   (br_taken),
    .reg_target (reg_target),
    .pc_q       (pc_q),
    .seq_pc     (seq_pc),
    .br_tgt     (br_tgt),
    .jmp_tgt    (jmp_tgt),
    .npc        (npc),
    .link_val   (link_val),
    .link_we    (link_we)
);

// File: tb/npc_select_test.sv
module npc_select_test;

    localparam logic [31:0] RV = 32'h0040_0000;
    localparam logic [31:0] JR_INSTR = 32'h0000_0008;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        adv_en = 1'b0;
    logic [31:0] instr = 32'h0;
    logic        br_taken = 1'b0;
    logic [31:0] reg_target = 32'h0;
    logic [31:0] pc_q, seq_pc, br_tgt, jmp_tgt, npc, link_val;
    logic        link_we;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    npc_select uut (
        .clk(clk), .rst(rst), .adv_en(adv_en), .instr(instr),
        .br_taken(br_taken), .reg_target(reg_target), .pc_q(pc_q),
        .seq_pc(seq_pc), .br_tgt(br_tgt), .jmp_tgt(jmp_tgt), .npc(npc),
        .link_val(link_val), .link_we(link_we)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] e_seq(input logic [31:0] p);
        return p + 32'd4;
    endfunction

    function automatic logic [31:0] e_br(input logic [31:0] p, input logic [15:0] o);
        logic signed [31:0] d;
        d = 32'(signed'(o)) * 4;
        return p + 32'd4 + d;
    endfunction

    function automatic logic [31:0] e_jmp(input logic [31:0] p, input logic [25:0] x);
        logic [31:0] s;
        s = p + 32'd4;
        return (s & 32'hF000_0000) | (32'(x) * 4);
    endfunction

    task automatic load_pc(input logic [31:0] v);
        @(negedge clk);
        instr = JR_INSTR; reg_target = v; adv_en = 1'b1; br_taken = 1'b1;
        #1 chk("R8 jreg npc", npc, v);
        @(posedge clk); #1;
        chk("R10 load pc", pc_q, v);
        @(negedge clk);
        adv_en = 1'b0;
    endtask

    task automatic sweep_pc(input logic [31:0] p);
        load_pc(p);
        @(negedge clk);
        chk("R2 seq", seq_pc, e_seq(p));
        for (int k = 0; k < 65536 + 3; k += 241) begin
            logic [15:0] o;
            o = (k >= 65536) ? ((k == 65536) ? 16'h7FFF : 16'h8000) : 16'(k);
            instr = {6'd4, 5'd1, 5'd2, o}; br_taken = 1'b1;
            #1 chk("R3 br_tgt", br_tgt, e_br(p, o));
            chk("R6 beq taken", npc, e_br(p, o));
            instr = {6'd5, 5'd3, 5'd4, o}; br_taken = 1'b0;
            #1 chk("R6 bne not taken", npc, e_seq(p));
            chk("R9 no link", 32'(link_we), 32'd0);
        end
        for (int k = 0; k < 64; k++) begin
            logic [25:0] x;
            x = 26'(k * 32'h009E_3779) ^ 26'(k);
            if (k == 63) x = 26'h3FF_FFFF;
            instr = {6'd2, x}; br_taken = k[0];
            #1 chk("R4 jmp_tgt", jmp_tgt, e_jmp(p, x));
            chk("R5 j npc", npc, e_jmp(p, x));
            chk("R9 j no link", 32'(link_we), 32'd0);
            instr = {6'd3, x};
            #1 chk("R5 jal npc", npc, e_jmp(p, x));
            chk("R9 jal we", 32'(link_we), 32'd1);
            chk("R9 jal link", link_val, e_seq(p));
        end
        for (int op = 0; op < 64; op++) begin
            if (op != 2 && op != 3 && op != 4 && op != 5) begin
                instr = {6'(op), 10'h155, 16'hFFF9}; br_taken = 1'b1;
                #1 chk("R7 ignore br_taken", npc, e_seq(p));
                chk("R7 no link", 32'(link_we), 32'd0);
            end
        end
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        adv_en = 1'b1;
        repeat (3) @(posedge clk);
        #1 chk("R1 reset vector", pc_q, RV);
        @(negedge clk);
        rst = 1'b0; adv_en = 1'b0; instr = 32'h2000_0000;
        @(posedge clk); #1;
        chk("R10 hold on stall", pc_q, RV);
        @(negedge clk);
        adv_en = 1'b1;
        @(posedge clk); #1;
        chk("R10 advance seq", pc_q, RV + 32'd4);

        sweep_pc(RV);
        sweep_pc(32'hFFFF_FFFC);
        sweep_pc(32'h0FFF_FFFC);
        sweep_pc(32'h0000_1000);

        load_pc(32'd80020);
        @(negedge clk);
        instr = {6'd2, 26'd20000}; adv_en = 1'b1;
        #1 chk("R11 example npc", npc, 32'd80000);
        @(posedge clk); #1;
        chk("R11 example pc", pc_q, 32'd80000);

        @(negedge clk);
        instr = {6'd4, 16'h0, 16'hFFFF}; br_taken = 1'b1; adv_en = 1'b0;
        @(posedge clk); #1;
        chk("R10 stall keeps pc", pc_q, 32'd80000);

        @(negedge clk);
        rst = 1'b1; adv_en = 1'b0;
        @(posedge clk); #1;
        chk("R1 reset mid run", pc_q, RV);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule